// File: doc/BRIEF.md
# Vectored Interrupt Dispatch Controller

This block sits next to a small 8-bit core. It collects interrupt requests from twelve sources and chooses one to service. It then produces the program address that the core jumps to, and it models the dispatch timing cycle by cycle.

A request pulse is latched until the request is dispatched. The core reports instruction timing: it pulses `instStart` in the first cycle of every instruction and gives that instruction's length in cycles on `instCycles`. From these the block knows which cycle is the last one of the current instruction. A dispatch starts at that boundary when three things hold: an enabled request is pending, the global enable is set, and no dispatch is already running. A dispatch is a fixed call phase followed by a fixed vector jump phase. The first handler instruction is then flagged together with its vector address.

The vector table uses two-byte slots. Slot 0, at address 0x0000, is the reset entry. Sources 0 to 11 use slots 1 to 12, so the last slot sits at 0x0018. In source order the twelve sources are:
- USB bus reset
- fast periodic timer
- slow periodic timer
- first device address, endpoints 0, 1 and 2
- second device address, endpoints 0 and 1
- hub
- DAC
- GPIO
- I2C

Top module: `irq_dispatch`

## Requirements
- R1: While `rstN` is low, `vecAddr` is 0x0000, `busy` is 0, `srcAck` is 0 and `firstInstr` is 1. `firstInstr` stays 1 in the cycle in which `rstN` goes high and reads 0 after the next clock edge.
- R2: A dispatch of source i (0 to 11) sets `vecAddr` to 2*(i+1): source 0 gives 0x0002 and source 11 gives 0x0018. The value holds through the dispatch and afterwards.
- R3: A request that arrives while k cycles of the current instruction remain, counting the arrival cycle, produces a one-cycle `firstInstr` pulse exactly k+10+5 cycles after the arrival cycle. For a 5-cycle instruction this is 16 cycles when k=1 and 20 cycles when k=5.
- R4: `busy` is high for exactly 15 consecutive cycles per dispatch: the 10 call cycles and then the 5 jump cycles. They begin in the cycle after the boundary cycle.
- R5: When several enabled requests are pending at a boundary, the lowest source index is chosen. This is the source with the lowest vector address.
- R6: Requests stay latched until dispatched. `srcAck` pulses for one cycle, one-hot with bit i set for source i, in the first call cycle, and that pending request is cleared.
- R7: A request that arrives during a dispatch stays pending and is dispatched later.
- R8: A source whose `srcEn` bit is 0 is never dispatched, but its request stays pending. It is dispatched once the bit is set.
- R9: Starting a dispatch clears the global enable. No further dispatch starts until `gieSet` has been pulsed again.
- R10: Reset cannot be masked. It clears all pending requests and the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; vectors to 0x0000 |
| srcReq | input | 12 | Per-source request pulses, bit i = source i |
| srcEn | input | 12 | Per-source enable bits |
| gieSet | input | 1 | Pulse that sets the global interrupt enable |
| instStart | input | 1 | High in the first cycle of each core instruction |
| instCycles | input | 4 | Length in cycles of the instruction that starts, sampled with `instStart` |
| vecAddr | output | 16 | Vector address of the latest dispatch, or 0x0000 after reset |
| busy | output | 1 | Dispatch in progress (call or jump phase) |
| firstInstr | output | 1 | Strobe for the cycle in which the first handler instruction executes |
| srcAck | output | 12 | One-hot acknowledge of the dispatched source |

## Verification
A wrong phase count or a boundary that slips by one cycle appears at once as a `firstInstr` pulse outside its window of 16 to 20 cycles. It also changes the number of `busy` cycles in the same dispatch. A corrupted pending or enable state appears at the next instruction boundary: the wrong slot on `vecAddr`, a missing or unexpected `busy`, or an acknowledge on the wrong bit. The bench sweeps every source against every remaining-cycle count from 1 to 5 and computes the expected latency and address arithmetically.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CALL = 2'd1,
    PH_JUMP = 2'd2
  } phase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic take;  // dispatch starts at the end of this cycle
    logic busy;  // call or jump phase active
  } ctrlStrobe_t;
endpackage

// File: rtl/irq_dispatch_dp.sv
module irq_dispatch_dp
  import irq_dispatch_pkg::*;
#(
  parameter int NUM_SRC    = 12,
  parameter int ADDR_W     = 16,
  parameter int SLOT_BYTES = 2,
  parameter int LEN_W      = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic               instStart,
  input  logic [LEN_W-1:0]   instCycles,
  input  ctrlStrobe_t        ctrl,
  output logic               boundary,
  output logic               anyReady,
  output logic [ADDR_W-1:0]  vecAddr,
  output logic [NUM_SRC-1:0] srcAck
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] pendQ, pendD, ready, pickOh;
  logic [IDX_W-1:0]   pickIdx;
  logic [LEN_W-1:0]   remCnt;
  logic               found;

  // Same-cycle requests take part in the boundary decision (R3)
  assign ready    = (pendQ | srcReq) & srcEn;  // R8
  assign anyReady = |ready;

  // Lowest index wins (R5)
  always_comb begin
    pickOh  = '0;
    pickIdx = '0;
    found   = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (ready[i] && !found) begin
        pickOh[i] = 1'b1;
        pickIdx   = IDX_W'(i);
        found     = 1'b1;
      end
    end
  end

  // Pending latches: set by a pulse, cleared only when dispatched (R6, R7)
  for (genvar g = 0; g < NUM_SRC; g++) begin : gPend
    assign pendD[g] = (pendQ[g] | srcReq[g]) & ~(ctrl.take & pickOh[g]);
  end

  // Last cycle of the current instruction
  assign boundary = (!ctrl.busy && instStart && instCycles == LEN_W'(1)) ||
                    (remCnt == LEN_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ   <= '0;  // R10
      remCnt  <= '0;
      vecAddr <= '0;  // R1
      srcAck  <= '0;
    end else begin
      pendQ  <= pendD;
      srcAck <= ctrl.take ? pickOh : '0;
      if (ctrl.take)
        vecAddr <= ADDR_W'((int'(pickIdx) + 1) * SLOT_BYTES);  // R2
      if (ctrl.busy)
        remCnt <= '0;
      else if (instStart)
        remCnt <= (instCycles == '0) ? '0 : instCycles - LEN_W'(1);
      else if (remCnt != '0)
        remCnt <= remCnt - LEN_W'(1);
    end
  end

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(srcAck));  // R6
  AST_ACK_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    (srcAck != '0) |-> ((srcAck & $past(srcEn)) == srcAck));  // R8
  AST_VEC_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.busy && $past(ctrl.busy)) |-> $stable(vecAddr));  // R2
  AST_VEC_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (vecAddr % SLOT_BYTES == 0) && (vecAddr <= ADDR_W'(NUM_SRC * SLOT_BYTES)));  // R2
endmodule

// File: rtl/irq_dispatch_ctrl.sv
module irq_dispatch_ctrl
  import irq_dispatch_pkg::*;
#(
  parameter int CALL_CYC = 10,
  parameter int JUMP_CYC = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        boundary,
  input  logic        anyReady,
  input  logic        gieSet,
  output ctrlStrobe_t ctrl,
  output logic        firstInstr
);
  localparam int MAX_PH = (CALL_CYC > JUMP_CYC) ? CALL_CYC : JUMP_CYC;
  localparam int CNT_W  = $clog2(MAX_PH + 1);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic             gieQ;
  logic             callLast, jumpLast;

  assign callLast  = (cnt == CNT_W'(CALL_CYC - 1));
  assign jumpLast  = (cnt == CNT_W'(JUMP_CYC - 1));
  assign ctrl.busy = (phase != PH_IDLE);
  assign ctrl.take = (phase == PH_IDLE) && boundary && gieQ && anyReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      cnt        <= '0;
      gieQ       <= 1'b0;  // R10
      firstInstr <= 1'b1;  // reset vector entry (R1)
    end else begin
      firstInstr <= (phase == PH_JUMP) && jumpLast;  // R3
      if (ctrl.take)      gieQ <= 1'b0;  // R9
      else if (gieSet)    gieQ <= 1'b1;
      case (phase)
        PH_IDLE: if (ctrl.take) begin
          phase <= PH_CALL;
          cnt   <= '0;
        end
        PH_CALL: if (callLast) begin
          phase <= PH_JUMP;
          cnt   <= '0;
        end else cnt <= cnt + CNT_W'(1);
        PH_JUMP: if (jumpLast) begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end else cnt <= cnt + CNT_W'(1);
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.take |=> ctrl.busy);  // R4
  AST_GIE_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.take |=> !gieQ);  // R9
  AST_FIRST_AFTER_JUMP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(firstInstr) |-> $past(ctrl.busy));  // R3
  AST_FIRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (firstInstr && $past(ctrl.busy)) |=> !firstInstr);  // R3
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_dispatch_pkg::*;
#(
  parameter int NUM_SRC    = 12,
  parameter int ADDR_W     = 16,
  parameter int SLOT_BYTES = 2,
  parameter int LEN_W      = 4,
  parameter int CALL_CYC   = 10,
  parameter int JUMP_CYC   = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic               gieSet,
  input  logic               instStart,
  input  logic [LEN_W-1:0]   instCycles,
  output logic [ADDR_W-1:0]  vecAddr,
  output logic               busy,
  output logic               firstInstr,
  output logic [NUM_SRC-1:0] srcAck
);
  ctrlStrobe_t ctrl;
  logic        boundary, anyReady;

  irq_dispatch_dp #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .SLOT_BYTES(SLOT_BYTES), .LEN_W(LEN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .srcEn(srcEn),
    .instStart(instStart), .instCycles(instCycles), .ctrl(ctrl),
    .boundary(boundary), .anyReady(anyReady), .vecAddr(vecAddr), .srcAck(srcAck)
  );

  irq_dispatch_ctrl #(
    .CALL_CYC(CALL_CYC), .JUMP_CYC(JUMP_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .boundary(boundary), .anyReady(anyReady),
    .gieSet(gieSet), .ctrl(ctrl), .firstInstr(firstInstr)
  );

  assign busy = ctrl.busy;
endmodule

// File: tb/irq_dispatch_tb.sv
module irq_dispatch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 12;
  localparam int WATCHDOG = 100000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  srcReq = '0;
  logic [N-1:0]  srcEn = '0;
  logic          gieSet = 1'b0;
  logic          instStart = 1'b0;
  logic [3:0]    instCycles = '0;
  logic [15:0]   vecAddr;
  logic          busy, firstInstr;
  logic [N-1:0]  srcAck;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int wdog = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_dispatch u_dut (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .srcEn(srcEn), .gieSet(gieSet),
    .instStart(instStart), .instCycles(instCycles), .vecAddr(vecAddr),
    .busy(busy), .firstInstr(firstInstr), .srcAck(srcAck)
  );

  always @(posedge clk) begin
    wdog++;
    if (wdog >= WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<%0d", wdog, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
  endtask

  task automatic pulseGie();
    tick(); gieSet = 1'b1;
    tick(); gieSet = 1'b0;
  endtask

  // One-cycle instruction with an optional request in the same cycle
  task automatic shortInst(int reqIdx);
    tick(); instStart = 1'b1; instCycles = 4'd1;
    if (reqIdx >= 0) srcReq[reqIdx] = 1'b1;
    tick(); instStart = 1'b0; srcReq = '0;
  endtask

  task automatic waitFirst(output bit seen);
    int guard = 0;
    seen = 1'b0;
    while (!firstInstr && guard < 40) begin tick(); guard++; end
    seen = firstInstr;
  endtask

  task automatic noDispatch(string req);
    int b = 0;
    for (int i = 0; i < 4; i++) begin tick(); if (busy) b++; end
    check(b == 0, req, b, 0);
  endtask

  // Request lands with k cycles left of a 5-cycle instruction
  task automatic runLatency(int idx, int k);
    int reqCyc, busyCnt, ackCyc, ackVal, guard;
    reqCyc = 0; busyCnt = 0; ackCyc = -1; ackVal = 0; guard = 0;
    srcEn = '1;
    pulseGie();
    tick(); instStart = 1'b1; instCycles = 4'd5;
    if (k == 5) begin srcReq[idx] = 1'b1; reqCyc = cyc; end
    for (int c = 1; c < 5; c++) begin
      tick(); instStart = 1'b0; srcReq = '0;
      if (5 - k == c) begin srcReq[idx] = 1'b1; reqCyc = cyc; end
    end
    do begin
      tick(); srcReq = '0; instStart = 1'b0;
      if (srcAck != '0) begin ackCyc = cyc; ackVal = int'(srcAck); end
      if (busy) busyCnt++;
      guard++;
    end while (!firstInstr && guard < 60);
    check(cyc - reqCyc == k + 15, "R3 latency", cyc - reqCyc, k + 15);
    check(int'(vecAddr) == 2 * (idx + 1), "R2 vector", int'(vecAddr), 2 * (idx + 1));
    check(busyCnt == 15, "R4 busy cycles", busyCnt, 15);
    check(ackCyc - reqCyc == k, "R6 ack cycle", ackCyc - reqCyc, k);
    check(ackVal == (1 << idx), "R6 ack bit", ackVal, 1 << idx);
    tick();
    check(firstInstr == 1'b0, "R3 strobe width", int'(firstInstr), 0);
  endtask

  initial begin
    bit seen;
    // R1: reset state
    tick(); tick();
    check(vecAddr == 16'h0000, "R1 vec in reset", int'(vecAddr), 0);
    check(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    check(srcAck == '0, "R1 ack in reset", int'(srcAck), 0);
    check(firstInstr == 1'b1, "R1 first in reset", int'(firstInstr), 1);
    rstN = 1'b1;
    #1;
    check(firstInstr == 1'b1, "R1 first at release", int'(firstInstr), 1);
    tick();
    check(firstInstr == 1'b0, "R1 first after edge", int'(firstInstr), 0);
    check(vecAddr == 16'h0000, "R1 vec after release", int'(vecAddr), 0);

    // R2 R3 R4 R6: every source against every remaining count
    for (int idx = 0; idx < N; idx++)
      for (int k = 1; k <= 5; k++)
        runLatency(idx, k);

    // R5 priority, then R9 enable cleared, then R6 latched request
    srcEn = '1;
    tick(); srcReq[7] = 1'b1; srcReq[3] = 1'b1;
    tick(); srcReq = '0;
    noDispatch("R9 no dispatch before enable");
    pulseGie();
    shortInst(-1);
    waitFirst(seen);
    check(seen && vecAddr == 16'd8, "R5 lowest first", int'(vecAddr), 8);
    shortInst(-1);
    noDispatch("R9 enable cleared by dispatch");
    pulseGie();
    shortInst(-1);
    waitFirst(seen);
    check(seen && vecAddr == 16'd16, "R6 latched until served", int'(vecAddr), 16);

    // R8: masked source stays pending
    srcEn = '1; srcEn[5] = 1'b0;
    pulseGie();
    shortInst(5);
    noDispatch("R8 masked source");
    srcEn[5] = 1'b1;
    shortInst(-1);
    waitFirst(seen);
    check(seen && vecAddr == 16'd12, "R8 dispatched once enabled", int'(vecAddr), 12);

    // R7: request arriving mid-dispatch
    pulseGie();
    shortInst(2);
    tick(); tick(); tick();
    check(busy == 1'b1, "R7 dispatch running", int'(busy), 1);
    srcReq[0] = 1'b1;
    tick(); srcReq = '0;
    waitFirst(seen);
    check(seen && vecAddr == 16'd6, "R7 first dispatch", int'(vecAddr), 6);
    pulseGie();
    shortInst(-1);
    waitFirst(seen);
    check(seen && vecAddr == 16'd2, "R7 later dispatch", int'(vecAddr), 2);

    // R10: reset clears pending and global enable
    tick(); srcEn = '1; srcEn[4] = 1'b0; srcReq[4] = 1'b1;
    tick(); srcReq = '0;
    pulseGie();
    tick(); rstN = 1'b0;
    tick(); rstN = 1'b1;
    check(vecAddr == 16'h0000, "R10 vector reset", int'(vecAddr), 0);
    srcEn = '1;
    shortInst(-1);
    noDispatch("R10 enable cleared");
    pulseGie();
    shortInst(-1);
    noDispatch("R10 pending cleared");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule